// File: doc/BRIEF.md
# Port I/O Buffer Configuration Register Path

This block keeps one configuration word per port for the chip's I/O buffers and gives a serial test-access controller a way to read and write those words. The enclosing controller owns the test state machine; it hands this block a decoded operation code, two control bits, a port address taken from the instruction, and one-cycle shift and update strobes. Serial data enters on `tdi` and leaves on `tdo`.

Two serial registers sit between the controller and the storage. A staging register receives write data, and a mirror register takes a parallel copy of it on update. The mirror is also where a read lands. A single shift-out operation therefore returns whichever came last: the word most recently staged, or the word most recently read from a port. An access operation either copies an addressed port's word into the mirror or commits the staging register into that port's slot.

Top module: `ioc_cfg_path`

## Requirements
- R1: While `rst_n` is low, every port slot, the staging register and the mirror register are cleared to all zeros, which is the input-mode setting. `tdo` reads 0 after reset.
- R2: With `op`=2'b01 (stage), each `shift_dr` cycle moves `tdi` into bit 19 of the staging register and shifts the rest toward bit 0. `tdo` shows the current bit 0 of the staging register, so data leaves LSB first.
- R3: With `op`=2'b01, an `update_dr` cycle copies all 20 staging bits into the mirror register.
- R4: With `op`=2'b10 (mirror out), each `shift_dr` cycle shifts the mirror register LSB first, with `tdo` showing its bit 0 and `tdi` entering bit 19. The staging register is left unchanged.
- R5: With `op`=2'b11 (access) and `ctl`=2'b00, an `update_dr` cycle loads the mirror register with the slot selected by `addr`.
- R6: With `op`=2'b11 and `ctl`=2'b01, an `update_dr` cycle writes the staging register into the slot selected by `addr`. The mirror register keeps its value.
- R7: With `op`=2'b11 and `ctl` equal to 2'b10 or 2'b11, `update_dr` changes no slot and leaves the mirror register as it was.
- R8: An access whose `addr` is not below the port count (8 by default) reads nothing and writes nothing.
- R9: With `op`=2'b00 (idle) or 2'b11, `tdo` is 0 and `shift_dr` alters neither serial register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; all buffers go to input mode |
| op | input | 2 | Operation: 00 idle, 01 stage, 10 mirror out, 11 access |
| ctl | input | 2 | Access control: 00 read, 01 write, 10/11 ignored |
| addr | input | 10 | Port address from the instruction's low bits |
| shift_dr | input | 1 | One-cycle serial shift strobe |
| update_dr | input | 1 | One-cycle update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
The hardest case to reach from the ports is a mirror register that holds read-back data which differs from the staging register. The stimulus first stages one word and writes it into a slot. It then stages a different word, so the two registers disagree, and reads the slot back before shifting the mirror out. The same approach covers the ignored control codes and out-of-range addresses: the mirror is loaded with a known pattern, the ignored access is issued, and a full shift-out shows the pattern intact. Reading every slot afterwards shows that no slot was written.

// File: rtl/ioc_cfg_pkg.sv
package ioc_cfg_pkg;

  typedef enum logic [1:0] {
    OP_IDLE       = 2'b00,
    OP_STAGE      = 2'b01,
    OP_MIRROR_OUT = 2'b10,
    OP_ACCESS     = 2'b11
  } ioc_op_e;

  localparam logic [1:0] CTL_READ  = 2'b00;
  localparam logic [1:0] CTL_WRITE = 2'b01;

  // Port address validity: only slots below the port count exist.
  function automatic logic addr_in_range(input logic [31:0] a, input int unsigned n);
    return a < n;
  endfunction

endpackage

// File: rtl/ioc_shreg.sv
module ioc_shreg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  // Shift wins over a parallel load; the controller never issues both at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {sin, q[W-1:1]};
    else if (load_en)  q <= load_val;
  end
endmodule

// File: rtl/ioc_cfg_store.sv
module ioc_cfg_store #(
  parameter int W     = 20,
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_word
);
  logic [N-1:0][W-1:0] slot_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[g] <= '0;
      else if (wr_en && (idx == IDX_W'(g)))         slot_q[g] <= wdata;
    end
  end

  assign rd_word = slot_q[idx];
endmodule

// File: rtl/ioc_cfg_path.sv
module ioc_cfg_path #(
  parameter int CFG_W  = 20,
  parameter int PORTS  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op,
  input  logic [1:0]        ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo
);
  import ioc_cfg_pkg::*;

  localparam int IDX_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  ioc_op_e           op_e;
  logic              sel_stage, sel_mirror, sel_access, addr_ok;
  logic              stage_shift_ev, mirror_shift_ev, mirror_xfer_ev, rd_ev, wr_ev;
  logic [CFG_W-1:0]  data_q, copy_q, rd_word, copy_load_val;
  logic [IDX_W-1:0]  idx;

  assign op_e       = ioc_op_e'(op);
  assign sel_stage  = (op_e == OP_STAGE);
  assign sel_mirror = (op_e == OP_MIRROR_OUT);
  assign sel_access = (op_e == OP_ACCESS);
  assign addr_ok    = addr_in_range(32'(addr), PORTS);
  assign idx        = addr[IDX_W-1:0];

  // Named internal events
  assign stage_shift_ev  = shift_dr && sel_stage;
  assign mirror_shift_ev = shift_dr && sel_mirror;
  assign mirror_xfer_ev  = update_dr && sel_stage;
  assign rd_ev           = update_dr && sel_access && addr_ok && (ctl == CTL_READ);
  assign wr_ev           = update_dr && sel_access && addr_ok && (ctl == CTL_WRITE);

  assign copy_load_val = rd_ev ? rd_word : data_q;

  ioc_shreg #(.W(CFG_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .shift_en(stage_shift_ev), .sin(tdi),
    .load_en(1'b0), .load_val('0), .q(data_q)
  );

  ioc_shreg #(.W(CFG_W)) u_mirror (
    .clk(clk), .rst_n(rst_n), .shift_en(mirror_shift_ev), .sin(tdi),
    .load_en(mirror_xfer_ev || rd_ev), .load_val(copy_load_val), .q(copy_q)
  );

  ioc_cfg_store #(.W(CFG_W), .N(PORTS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ev), .idx(idx),
    .wdata(data_q), .rd_word(rd_word)
  );

  assign tdo = sel_stage  ? data_q[0] :
               sel_mirror ? copy_q[0] : 1'b0;
endmodule

// File: rtl/ioc_cfg_path_chk.sv
module ioc_cfg_path_chk #(
  parameter int CFG_W  = 20,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op,
  input logic [1:0]        ctl,
  input logic [ADDR_W-1:0] addr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              tdi,
  input logic              tdo,
  input logic              addr_ok,
  input logic              rd_ev,
  input logic              wr_ev,
  input logic [CFG_W-1:0]  data_q,
  input logic [CFG_W-1:0]  copy_q,
  input logic [CFG_W-1:0]  rd_word
);
  assert_stage_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && op == 2'b01) |=> (data_q == {$past(tdi), $past(data_q[CFG_W-1:1])}));

  assert_mirror_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (update_dr && !shift_dr && op == 2'b01) |=> (copy_q == $past(data_q)));

  assert_mirror_hold_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && op == 2'b10) |=> $stable(data_q));

  assert_read_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> (copy_q == $past(rd_word)));

  assert_write_keeps_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> $stable(copy_q));

  assert_ignored_ctl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (update_dr && !shift_dr && op == 2'b11 && ctl[1]) |=> $stable(copy_q));

  assert_oob_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (update_dr && !shift_dr && op == 2'b11 && !addr_ok) |=> $stable(copy_q));

  assert_oob_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> !(rd_ev || wr_ev));

  assert_tdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'b00 || op == 2'b11) |-> !tdo);

  assert_idle_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && (op == 2'b00 || op == 2'b11)) |=> ($stable(data_q) && $stable(copy_q)));

  logic unused_addr;
  assign unused_addr = ^addr;
endmodule

bind ioc_cfg_path ioc_cfg_path_chk #(.CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .ctl(ctl), .addr(addr),
  .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
  .addr_ok(addr_ok), .rd_ev(rd_ev), .wr_ev(wr_ev),
  .data_q(data_q), .copy_q(copy_q), .rd_word(rd_word)
);

// File: tb/sim_ioc_cfg_path.sv
module sim_ioc_cfg_path;
  localparam int W = 20;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'b00;
  logic [1:0] ctl = 2'b00;
  logic [9:0] addr = '0;
  logic       shift_dr = 1'b0;
  logic       update_dr = 1'b0;
  logic       tdi = 1'b0;
  logic       tdo;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench-side model of the requirements
  logic [W-1:0] stage_m = '0;
  logic [W-1:0] mirror_m = '0;
  logic [W-1:0] slot_m [N];

  logic  exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  ioc_cfg_path u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .ctl(ctl), .addr(addr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
  );

  // Monitor: samples tdo mid-phase on each shift cycle and pops the scoreboard
  always @(negedge clk) begin
    #5;
    if (shift_dr && exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (tdo !== e) begin
        failures++;
        $display("FAIL %s: tdo actual=%b expected=%b at %0t", t, tdo, e, $time);
      end
    end
  end

  // Driver: shift W bits of w under operation o, pushing expected tdo bits
  task automatic shift_word(input logic [1:0] o, input logic [W-1:0] w, input string tag);
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      op = o; shift_dr = 1'b1; tdi = w[i];
      if (o == 2'b01)      exp_q.push_back(stage_m[0]);
      else if (o == 2'b10) exp_q.push_back(mirror_m[0]);
      else                 exp_q.push_back(1'b0);
      tag_q.push_back(tag);
      if (o == 2'b01)      stage_m  = {w[i], stage_m[W-1:1]};
      else if (o == 2'b10) mirror_m = {w[i], mirror_m[W-1:1]};
    end
    @(negedge clk);
    shift_dr = 1'b0;
  endtask

  task automatic update(input logic [1:0] o, input logic [1:0] c, input int a);
    @(negedge clk);
    op = o; ctl = c; addr = 10'(a); update_dr = 1'b1;
    if (o == 2'b01) mirror_m = stage_m;
    else if (o == 2'b11 && a < N) begin
      if (c == 2'b00)      mirror_m = slot_m[a];
      else if (c == 2'b01) slot_m[a] = stage_m;
    end
    @(negedge clk);
    update_dr = 1'b0;
  endtask

  // Read slot a into the mirror, then shift it out (zeros refill)
  task automatic read_slot(input int a, input string tag);
    update(2'b11, 2'b00, a);
    shift_word(2'b10, '0, tag);
  endtask

  task automatic put_slot(input int a, input logic [W-1:0] w);
    shift_word(2'b01, w, "R2");
    update(2'b11, 2'b01, a);
  endtask

  initial begin
    for (int i = 0; i < N; i++) slot_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #5; checks++;
    if (tdo !== 1'b0) begin failures++; $display("FAIL R1: tdo actual=%b expected=0", tdo); end
    shift_word(2'b10, '0, "R1");
    shift_word(2'b01, 20'hA5C3F, "R1");
    for (int a = 0; a < N; a++) read_slot(a, "R1");

    // R2: staged data shifts out LSB first on the next pass
    shift_word(2'b01, 20'h12345, "R2");
    // R3: update under stage copies into mirror
    update(2'b01, 2'b00, 0);
    shift_word(2'b10, 20'hFFFFF, "R3");
    // R4: mirror out refills from tdi; stage untouched
    shift_word(2'b10, 20'h0F0F0, "R4");
    shift_word(2'b01, 20'h55555, "R4");

    // R6: writes, mirror unaffected
    put_slot(3, 20'hBEEF1);
    put_slot(7, 20'h80001);
    put_slot(0, 20'h3C3C3);
    shift_word(2'b01, 20'h77777, "R6");   // stage differs from slots
    update(2'b01, 2'b00, 0);              // mirror = known pattern
    update(2'b11, 2'b01, 5);              // write slot 5
    shift_word(2'b10, 20'h00000, "R6");   // mirror still the pattern

    // R5: read-back lands in mirror even though stage differs
    read_slot(3, "R5");
    read_slot(7, "R5");
    read_slot(5, "R5");

    // R7: ignored control codes
    shift_word(2'b01, 20'hC0DE5, "R7");
    update(2'b01, 2'b00, 0);
    update(2'b11, 2'b10, 3);
    update(2'b11, 2'b11, 3);
    shift_word(2'b10, 20'h00000, "R7");
    read_slot(3, "R7");

    // R8: out-of-range addresses
    shift_word(2'b01, 20'h9ABCD, "R8");
    update(2'b01, 2'b00, 0);
    update(2'b11, 2'b00, 8);
    update(2'b11, 2'b01, 1023);
    update(2'b11, 2'b01, 11);             // low bits alias slot 3
    shift_word(2'b10, 20'h00000, "R8");
    for (int a = 0; a < N; a++) read_slot(a, "R8");

    // R9: idle and access ops keep tdo low and registers still
    shift_word(2'b01, 20'h6D6D6, "R9");
    update(2'b01, 2'b00, 0);
    shift_word(2'b00, 20'hFFFFF, "R9");
    shift_word(2'b11, 20'hAAAAA, "R9");
    shift_word(2'b01, 20'h00000, "R9");
    shift_word(2'b10, 20'h00000, "R9");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule